// File: doc/BRIEF.md
# Dual-Window Watchdog Supervisor

This block supervises a host processor. The host proves it is alive by pulsing a trigger input inside a timed window, and it tells the block whether it is running at full speed or sleeping through a mode input. When a power-on reset input is released, the block holds the host in reset for a fixed time. It then waits for the host to confirm the handshake by pulling mode low. After that it checks the trigger against a repeating window that is closed first and then open. A trigger in the wrong place, a trigger held high too long, or a missing trigger pulls the active-low reset output low for a fixed pulse. After every such pulse the handshake wait starts again.

While the host runs at full speed, the short window applies. The enable output goes high only after three correct triggers in a row, and it falls on any fault. When mode is high, the block uses a much longer window, and a time-select input picks one of two long durations. In this mode enable stays low. The long window also wakes a sleeping host on a regular schedule, because a missing trigger produces a reset pulse. A wake-up input ends long mode at once with a reset pulse. All durations are counted in cycles of the block clock. The inputs are assumed to be already synchronous and free of bounce.

Top module: `wdog_supervisor`

## Requirements
- R1: While `por` is high the reset output `rstOutN` is low. After `por` falls, `rstOutN` stays low for exactly POR_HOLD rising clock edges that sample `por` low, and then goes high. Default POR_HOLD is 201.
- R2: After any reset phase ends, the block waits for `modeIn` to be low. A low level enters short monitoring on the next edge. If `modeIn` stays high for MODE_TMO cycles (default 1112), the block issues a reset pulse, and the wait restarts after that pulse.
- R3: Every reset pulse the watchdog generates holds `rstOutN` low for exactly RST_LEN cycles (default 40). The mode-handshake wait follows each pulse.
- R4: In short mode, each cycle is S_CLOSED cycles closed (default 130) followed by S_OPEN cycles open (default 124). A trigger rising edge in the open window is accepted and starts a new cycle at the closed window.
- R5: A trigger rising edge in the short closed window produces a reset pulse. So does reaching the end of the short open window without a rising edge.
- R6: A trigger that stays high for TRIG_MAX consecutive cycles (default 45) is accepted. One that is still high on the next cycle produces a reset pulse. This applies in short and long mode.
- R7: `enOut` goes high on the cycle after the third consecutive accepted trigger. Any fault or reset pulse clears it, and the count of three starts again.
- R8: While in short mode, a high `modeIn` switches to long mode and restarts the window at its closed part. `enOut` is low in every state except short monitoring.
- R9: In long mode, the closed and open windows are LA_CLOSED and LA_OPEN cycles (default 71970 and 30002) when `tselIn` is 0. They are LB_CLOSED and LB_OPEN cycles (default 1200 and 400) when `tselIn` is 1.
- R10: In long mode, an early trigger rising edge in the closed window produces a reset pulse, and so does a missing trigger at the end of the open window. An accepted trigger restarts the long window.
- R11: A high `wakeIn` during long mode produces a reset pulse on the next edge, and the mode-handshake wait starts again after it. `wakeIn` has no effect in any other state.
- R12: In long mode, a low `modeIn` returns the block to short mode with a fresh short closed window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock; all timing is counted in its cycles |
| por | input | 1 | Power-on reset, active high, sampled synchronously |
| trigIn | input | 1 | Trigger from the host; its rising edge is the heartbeat |
| modeIn | input | 1 | Host mode: low selects short monitoring, high selects long monitoring |
| tselIn | input | 1 | Selects one of two long-window timings |
| wakeIn | input | 1 | Wake-up event, active high, acted on only in long mode |
| rstOutN | output | 1 | Reset to the host, active low (low = drive, high = released) |
| enOut | output | 1 | Enable for safety peripherals, active high |

## Verification
The hardest case to reach from the ports is a trigger edge that lands exactly on a window boundary. This means the last closed cycle against the first open cycle, and the last open cycle against the timeout, in short mode and in both long timings. The bench handles it by restarting from a known handshake point after every reset pulse. From there it sweeps the trigger's rising edge over every cycle offset of the window. For each offset it computes the cycle of the expected reset pulse with simple arithmetic, and it checks the output on that cycle and on the cycle before. The enable qualification, a pulse width held right at its limit, and a wake-up arriving in long mode and then outside it are reached the same way, by counting cycles from the handshake point.

// File: rtl/wds_pkg.sv
package wds_pkg;

  typedef enum logic [2:0] {
    ST_POR,    // power-up hold
    ST_PULSE,  // watchdog reset pulse
    ST_HSHK,   // waiting for mode low
    ST_SCLS,   // short window, closed
    ST_SOPN,   // short window, open
    ST_LCLS,   // long window, closed
    ST_LOPN    // long window, open
  } wdsState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;   // clear the window counter
    logic goodTrig;  // accepted trigger in short mode
    logic clrGood;   // drop the good-trigger tally
  } wdsStrobe_t;

endpackage

// File: rtl/wds_timer.sv
module wds_timer
  import wds_pkg::*;
#(
  parameter int CW       = 17,
  parameter int TRIG_MAX = 45,
  parameter int GOOD_N   = 3
) (
  input  logic          clk,
  input  logic          por,
  input  logic          trigIn,
  input  wdsStrobe_t    strobe,
  output logic [CW-1:0] winCnt,
  output logic          trigRise,
  output logic          trigLong,
  output logic          goodDone
);

  localparam int HW = $clog2(TRIG_MAX + 1);
  localparam int GW = $clog2(GOOD_N + 1);

  logic          trigPrev;
  logic [HW-1:0] hiCnt;
  logic [GW-1:0] goodCnt;

  always_ff @(posedge clk) begin
    if (por) begin
      winCnt   <= '0;
      trigPrev <= 1'b0;
      hiCnt    <= '0;
      goodCnt  <= '0;
    end else begin
      winCnt   <= strobe.restart ? '0 : winCnt + 1'b1;
      trigPrev <= trigIn;
      if (!trigIn)
        hiCnt <= '0;
      else if (hiCnt != HW'(TRIG_MAX))
        hiCnt <= hiCnt + 1'b1;
      if (strobe.clrGood)
        goodCnt <= '0;
      else if (strobe.goodTrig && !goodDone)
        goodCnt <= goodCnt + 1'b1;
    end
  end

  assign trigRise = trigIn && !trigPrev;
  assign trigLong = trigIn && (hiCnt == HW'(TRIG_MAX));
  assign goodDone = (goodCnt == GW'(GOOD_N));

endmodule

// File: rtl/wds_ctrl.sv
module wds_ctrl
  import wds_pkg::*;
#(
  parameter int CW        = 17,
  parameter int POR_HOLD  = 201,
  parameter int MODE_TMO  = 1112,
  parameter int RST_LEN   = 40,
  parameter int S_CLOSED  = 130,
  parameter int S_OPEN    = 124,
  parameter int LA_CLOSED = 71970,
  parameter int LA_OPEN   = 30002,
  parameter int LB_CLOSED = 1200,
  parameter int LB_OPEN   = 400
) (
  input  logic          clk,
  input  logic          por,
  input  logic          modeIn,
  input  logic          tselIn,
  input  logic          wakeIn,
  input  logic [CW-1:0] winCnt,
  input  logic          trigRise,
  input  logic          trigLong,
  input  logic          goodDone,
  output wdsStrobe_t    strobe,
  output wdsState_t     state,
  output logic          rstOutN,
  output logic          enOut
);

  wdsState_t     nxt;
  logic [CW-1:0] lastVal;
  logic          lastCyc, isShort, isLong, isClosed, isOpen, fault;

  always_comb begin
    case (state)
      ST_POR:   lastVal = CW'(POR_HOLD - 1);
      ST_PULSE: lastVal = CW'(RST_LEN - 1);
      ST_HSHK:  lastVal = CW'(MODE_TMO - 1);
      ST_SCLS:  lastVal = CW'(S_CLOSED - 1);
      ST_SOPN:  lastVal = CW'(S_OPEN - 1);
      ST_LCLS:  lastVal = tselIn ? CW'(LB_CLOSED - 1) : CW'(LA_CLOSED - 1);
      ST_LOPN:  lastVal = tselIn ? CW'(LB_OPEN - 1) : CW'(LA_OPEN - 1);
      default:  lastVal = '0;
    endcase
  end

  assign lastCyc  = (winCnt == lastVal);
  assign isShort  = (state == ST_SCLS) || (state == ST_SOPN);
  assign isLong   = (state == ST_LCLS) || (state == ST_LOPN);
  assign isClosed = (state == ST_SCLS) || (state == ST_LCLS);
  assign isOpen   = (state == ST_SOPN) || (state == ST_LOPN);
  assign fault    = (isShort || isLong) &&
                    (trigLong || (isClosed && trigRise) ||
                     (isOpen && lastCyc && !trigRise) || (isLong && wakeIn));

  always_comb begin
    nxt            = state;
    strobe.restart  = 1'b0;
    strobe.goodTrig = 1'b0;
    strobe.clrGood  = !isShort;
    case (state)
      ST_POR, ST_PULSE: if (lastCyc) begin
        nxt = ST_HSHK;
        strobe.restart = 1'b1;
      end
      ST_HSHK: if (!modeIn) begin
        nxt = ST_SCLS;
        strobe.restart = 1'b1;
      end else if (lastCyc) begin
        nxt = ST_PULSE;
        strobe.restart = 1'b1;
      end
      default: if (fault) begin
        nxt = ST_PULSE;
        strobe.restart = 1'b1;
        strobe.clrGood = 1'b1;
      end else if (isOpen && trigRise) begin
        nxt = isShort ? ST_SCLS : ST_LCLS;
        strobe.restart  = 1'b1;
        strobe.goodTrig = isShort;
      end else if (isShort && modeIn) begin
        nxt = ST_LCLS;
        strobe.restart = 1'b1;
      end else if (isLong && !modeIn) begin
        nxt = ST_SCLS;
        strobe.restart = 1'b1;
      end else if (isClosed && lastCyc) begin
        nxt = isShort ? ST_SOPN : ST_LOPN;
        strobe.restart = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (por) state <= ST_POR;
    else     state <= nxt;
  end

  assign rstOutN = !((state == ST_POR) || (state == ST_PULSE));
  assign enOut   = isShort && goodDone;

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wds_pkg::*;
#(
  parameter int POR_HOLD  = 201,
  parameter int MODE_TMO  = 1112,
  parameter int RST_LEN   = 40,
  parameter int S_CLOSED  = 130,
  parameter int S_OPEN    = 124,
  parameter int TRIG_MAX  = 45,
  parameter int LA_CLOSED = 71970,
  parameter int LA_OPEN   = 30002,
  parameter int LB_CLOSED = 1200,
  parameter int LB_OPEN   = 400,
  parameter int GOOD_N    = 3
) (
  input  logic clk,
  input  logic por,
  input  logic trigIn,
  input  logic modeIn,
  input  logic tselIn,
  input  logic wakeIn,
  output logic rstOutN,
  output logic enOut
);

  localparam int M1 = (POR_HOLD > MODE_TMO) ? POR_HOLD : MODE_TMO;
  localparam int M2 = (LA_CLOSED > LA_OPEN) ? LA_CLOSED : LA_OPEN;
  localparam int M3 = (LB_CLOSED > LB_OPEN) ? LB_CLOSED : LB_OPEN;
  localparam int M4 = (S_CLOSED > S_OPEN) ? S_CLOSED : S_OPEN;
  localparam int M5 = (M1 > M2) ? M1 : M2;
  localparam int M6 = (M3 > M4) ? M3 : M4;
  localparam int M7 = (M5 > M6) ? M5 : M6;
  localparam int MX = (M7 > RST_LEN) ? M7 : RST_LEN;
  localparam int CW = $clog2(MX + 1);

  wdsStrobe_t    strobe;
  wdsState_t     ctrlState;
  logic [CW-1:0] winCnt;
  logic          trigRise, trigLong, goodDone;

  wds_timer #(.CW(CW), .TRIG_MAX(TRIG_MAX), .GOOD_N(GOOD_N)) uTimer (
    .clk(clk), .por(por), .trigIn(trigIn), .strobe(strobe),
    .winCnt(winCnt), .trigRise(trigRise), .trigLong(trigLong), .goodDone(goodDone)
  );

  wds_ctrl #(
    .CW(CW), .POR_HOLD(POR_HOLD), .MODE_TMO(MODE_TMO), .RST_LEN(RST_LEN),
    .S_CLOSED(S_CLOSED), .S_OPEN(S_OPEN), .LA_CLOSED(LA_CLOSED), .LA_OPEN(LA_OPEN),
    .LB_CLOSED(LB_CLOSED), .LB_OPEN(LB_OPEN)
  ) uCtrl (
    .clk(clk), .por(por), .modeIn(modeIn), .tselIn(tselIn), .wakeIn(wakeIn),
    .winCnt(winCnt), .trigRise(trigRise), .trigLong(trigLong), .goodDone(goodDone),
    .strobe(strobe), .state(ctrlState), .rstOutN(rstOutN), .enOut(enOut)
  );

endmodule

// File: rtl/wds_chk.sv
module wds_chk
  import wds_pkg::*;
#(
  parameter int RST_LEN = 40
) (
  input logic      clk,
  input logic      por,
  input logic      trigIn,
  input logic      modeIn,
  input logic      wakeIn,
  input logic      rstOutN,
  input logic      enOut,
  input logic      goodTrig,
  input wdsState_t state
);

  logic [15:0] lowRun;
  logic        porRun;

  always_ff @(posedge clk) begin
    if (por) begin
      lowRun <= '0;
      porRun <= 1'b1;
    end else if (!rstOutN) begin
      if (lowRun != 16'hFFFF) lowRun <= lowRun + 1'b1;
    end else begin
      lowRun <= '0;
      porRun <= 1'b0;
    end
  end

  AST_POR_HOLDS_RESET: assert property (@(posedge clk) por |=> !rstOutN); // R1

  AST_HSHK_TO_SHORT: assert property (@(posedge clk) disable iff (por)
    (state == ST_HSHK && !modeIn) |=> (state == ST_SCLS)); // R2

  AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (por)
    ($rose(rstOutN) && !porRun) |-> (lowRun == 16'(RST_LEN))); // R3

  AST_EARLY_TRIG_RESETS: assert property (@(posedge clk) disable iff (por)
    (state == ST_SCLS && trigIn && !$past(trigIn)) |=> !rstOutN); // R5

  AST_ENABLE_AFTER_GOOD: assert property (@(posedge clk) disable iff (por)
    $rose(enOut) |-> $past(goodTrig)); // R7

  AST_ENABLE_SHORT_ONLY: assert property (@(posedge clk) disable iff (por)
    enOut |-> (rstOutN && (state == ST_SCLS || state == ST_SOPN))); // R8

  AST_WAKE_RESETS: assert property (@(posedge clk) disable iff (por)
    ((state == ST_LCLS || state == ST_LOPN) && wakeIn) |=> !rstOutN); // R11

endmodule

bind wdog_supervisor wds_chk #(.RST_LEN(RST_LEN)) uChk (
  .clk(clk), .por(por), .trigIn(trigIn), .modeIn(modeIn), .wakeIn(wakeIn),
  .rstOutN(rstOutN), .enOut(enOut), .goodTrig(strobe.goodTrig), .state(ctrlState)
);

// File: tb/wdog_supervisor_test.sv
`timescale 1ns/1ps
module wdog_supervisor_test;

  localparam int PORH = 5, TMO = 12, RSTL = 4, SC = 6, SO = 5, TMAX = 3;
  localparam int LAC = 10, LAO = 6, LBC = 7, LBO = 3;

  logic clk = 0, por = 1, trig = 0, mode = 1, tsel = 0, wake = 0;
  wire  rstN, en;
  int   checks = 0, errors = 0;
  bit   done = 0;

  wdog_supervisor #(
    .POR_HOLD(PORH), .MODE_TMO(TMO), .RST_LEN(RSTL), .S_CLOSED(SC), .S_OPEN(SO),
    .TRIG_MAX(TMAX), .LA_CLOSED(LAC), .LA_OPEN(LAO), .LB_CLOSED(LBC), .LB_OPEN(LBO),
    .GOOD_N(3)
  ) uut (
    .clk(clk), .por(por), .trigIn(trig), .modeIn(mode), .tselIn(tsel),
    .wakeIn(wake), .rstOutN(rstN), .enOut(en)
  );

  always #2.5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic lowRun(output int n);
    n = 0;
    while (!rstN) begin n++; @(negedge clk); end
  endtask

  task automatic highRun(output int n);
    n = 0;
    while (rstN) begin n++; @(negedge clk); end
  endtask

  task automatic waitHigh();
    while (!rstN) @(negedge clk);
  endtask

  // from the handshake point N (mode low): optional switch to long at j=d,
  // one-cycle trigger at j=k; check the reset pulse arrives where expected
  task automatic winTest(int d, int c, int o, int k, string early, string late);
    int ef;
    string tag;
    if (k <= d + c)          begin ef = k + 1;         tag = early; end
    else if (k <= d + c + o) begin ef = k + c + o + 1; tag = late;  end
    else                     begin ef = d + c + o + 1; tag = late;  end
    for (int j = 1; j <= ef; j++) begin
      @(negedge clk);
      if (j == ef - 1) check(tag, rstN, 1);
      if (j == ef)     check(tag, rstN, 0);
      if (d > 0 && j == d) mode = 1;
      if (j == k)          trig = 1;
      if (j == k + 1)      trig = 0;
    end
    trig = 0; mode = 0;
    waitHigh();
  endtask

  initial begin
    int n, k3, m2;
    repeat (3) @(negedge clk);
    check("R1 rst during por", rstN, 0);
    check("R8 en during por", en, 0);
    por = 0;
    lowRun(n);  check("R1 por hold length", n, PORH);
    highRun(n); check("R2 handshake timeout", n, TMO);
    lowRun(n);  check("R3 pulse length", n, RSTL);
    highRun(n); check("R2 timeout restarts", n, TMO);
    lowRun(n);  check("R3 pulse length again", n, RSTL);
    mode = 0;

    // short window sweep
    for (int k = 1; k <= SC + SO + 1; k++) winTest(0, SC, SO, k, "R5 early", "R4 window");
    // long window sweeps, both timings
    tsel = 0;
    for (int k = 3; k <= 2 + LAC + LAO + 1; k++) winTest(2, LAC, LAO, k, "R10 early", "R9 long A");
    tsel = 1;
    for (int k = 3; k <= 2 + LBC + LBO + 1; k++) winTest(2, LBC, LBO, k, "R10 early", "R9 long B");
    tsel = 0;

    // enable after three goods, third pulse exactly TMAX wide, then long and back
    k3 = 3 * (SC + 2);
    m2 = k3 + TMAX + 4;
    for (int j = 1; j <= m2 + SC + SO + 1; j++) begin
      @(negedge clk);
      if (j == k3)            check("R7 en low after two", en, 0);
      if (j == k3 + 1)        check("R7 en high after three", en, 1);
      if (j == k3 + TMAX + 1) check("R6 width TMAX accepted", rstN, 1);
      if (j == k3 + TMAX + 2) check("R8 en low in long", en, 0);
      if (j == m2 + 2)        check("R12 en low after return", en, 0);
      if (j == m2 + SC + SO)     check("R12 short timing high", rstN, 1);
      if (j == m2 + SC + SO + 1) check("R12 short timing low", rstN, 0);
      if (j == SC + 2 || j == 2 * (SC + 2) || j == k3) trig = 1;
      if (j == SC + 3 || j == 2 * (SC + 2) + 1 || j == k3 + TMAX) trig = 0;
      if (j == k3 + TMAX + 1) mode = 1;
      if (j == m2) mode = 0;
    end
    waitHigh();

    // too-long pulse on the third trigger
    for (int j = 1; j <= k3 + TMAX + 1; j++) begin
      @(negedge clk);
      if (j == k3 + 1)        check("R7 en high", en, 1);
      if (j == k3 + TMAX)     check("R6 width limit high", rstN, 1);
      if (j == k3 + TMAX + 1) check("R6 too long resets", rstN, 0);
      if (j == k3 + TMAX + 1) check("R7 fault clears en", en, 0);
      if (j == SC + 2 || j == 2 * (SC + 2) || j == k3) trig = 1;
      if (j == SC + 3 || j == 2 * (SC + 2) + 1 || j == k3 + TMAX + 1) trig = 0;
    end
    waitHigh();

    // count restarts after the fault
    for (int j = 1; j <= k3 + SC + SO + 1; j++) begin
      @(negedge clk);
      if (j == 2 * (SC + 2) + 1) check("R7 restart two not enough", en, 0);
      if (j == k3 + 1)           check("R7 restart three", en, 1);
      if (j == k3 + SC + SO + 1) check("R5 timeout after goods", rstN, 0);
      if (j == SC + 2 || j == 2 * (SC + 2) || j == k3) trig = 1;
      if (j == SC + 3 || j == 2 * (SC + 2) + 1 || j == k3 + 1) trig = 0;
    end
    waitHigh();

    // wake ignored in short mode
    for (int j = 1; j <= SC + SO + 1; j++) begin
      @(negedge clk);
      if (j >= 2 && j <= 4)  check("R11 wake ignored in short", rstN, 1);
      if (j == SC + SO + 1)  check("R11 short timing kept", rstN, 0);
      if (j == 1) wake = 1;
      if (j == 4) wake = 0;
    end
    waitHigh();

    // wake in long mode
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      if (j == 5) check("R11 no reset before wake", rstN, 1);
      if (j == 6) check("R11 wake resets", rstN, 0);
      if (j == 2) mode = 1;
      if (j == 5) wake = 1;
    end
    wake = 0;
    lowRun(n);  check("R11 wake pulse length", n, RSTL);
    highRun(n); check("R11 handshake restarts", n, TMO);
    mode = 0;
    waitHigh();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule